// File: doc/BRIEF.md
# Display Interrupt Status Unit

This unit gathers single-cycle event pulses from a display pipeline into a sticky raw status vector, filters that vector through an enable mask, and drives one level interrupt line toward the processor. Software reaches it through a plain register port: a write strobe with address and data, and a separate read address that returns data in the same cycle. Event generation is outside this block.

Enable bits are never written directly. One address sets the enable bits written as one, another address clears them. Status bits are cleared by writing ones to either status address. Once the line rises it stays high until software writes the end-of-service address. That write drops the line and re-arms the unit, so a condition that is still pending raises the line again one cycle later.

Five status positions are implemented, because the pipeline and the software decode them at these positions: bit 2 (sync lost), bit 5 (FIFO underflow), bit 6 (palette load done), bit 8 (frame 0 done) and bit 9 (frame 1 done). Every other bit is tied to zero.

Top module: `disp_irq_status`

## Requirements
- R1: A one on an implemented bit of `evt_i` at a rising clock edge sets that raw status bit at the same edge. The bit stays set until software clears it.
- R2: A write to address 0 (raw status) or to address 1 (masked status) clears exactly the raw bits written as one. Bits written as zero, and writes to addresses 5 to 7, leave the status unchanged.
- R3: When an event pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R4: A write to address 2 sets the enable bits written as one, and a write to address 3 clears the enable bits written as one. A read of address 2 or address 3 returns the current enable mask.
- R5: A read of address 0 returns the raw status. A read of address 1 returns the raw status ANDed with the enable mask.
- R6: While `irq_o` is low and the masked status is nonzero, `irq_o` goes high at the next rising edge, unless an end-of-service write happens in that cycle.
- R7: Once high, `irq_o` stays high until an end-of-service write, even if every status bit is cleared.
- R8: A write to address 4 (end of service) makes `irq_o` low at the next edge. If the masked status is still nonzero, the line rises again one cycle later. A read of address 4 returns zero.
- R9: Only bits 2, 5, 6, 8 and 9 can ever be set in the raw status or the enable mask. All other bits read as zero.
- R10: After reset, the raw status and the enable mask are zero and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | STAT_W | Event pulses from the pipeline, one bit per status position |
| reg_wr_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 3 | Write address |
| reg_wdata_i | input | STAT_W | Write data |
| reg_raddr_i | input | 3 | Read address |
| reg_rdata_o | output | STAT_W | Read data, combinational from the read address |
| irq_o | output | 1 | Interrupt line |

## Verification
A raw bit that fails to set, or that clears on its own, shows up on the next read of address 0 or 1. When that bit is enabled, it also shows one cycle later as a line that does not rise, or rises when it should not. A corrupted enable bit appears straight away on a read of address 2 or 3, and as a wrong masked value. Tests that hold both an event and a clear on one bit in the same cycle cover the ordering of those two actions. Reads right after each end-of-service write cover the arming state: a missing re-arm leaves the line low one cycle after the write while a masked bit is still pending, and a missing drop leaves the line high in the cycle after the write.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int unsigned ISU_AW = 3;

  typedef enum logic [ISU_AW-1:0] {
    ADR_RAW  = 3'd0,
    ADR_MSK  = 3'd1,
    ADR_ENS  = 3'd2,
    ADR_ENC  = 3'd3,
    ADR_EOI  = 3'd4
  } isu_addr_e;
endpackage

// File: rtl/isu_raw_bank.sv
module isu_raw_bank #(
  parameter int unsigned         STAT_W    = 10,
  parameter logic [STAT_W-1:0]   IMPL_MASK = 10'h364
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] raw_o
);
  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        bit_q <= 1'b0;
      else if (IMPL_MASK[b] && evt_i[b])
        bit_q <= 1'b1;            // event beats a same-cycle clear
      else if (clr_i[b])
        bit_q <= 1'b0;
    end
    assign raw_o[b] = bit_q & IMPL_MASK[b];
  end
endmodule

// File: rtl/isu_enable_bank.sv
module isu_enable_bank #(
  parameter int unsigned         STAT_W    = 10,
  parameter logic [STAT_W-1:0]   IMPL_MASK = 10'h364
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] en_o
);
  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        bit_q <= 1'b0;
      else if (set_i[b] && IMPL_MASK[b])
        bit_q <= 1'b1;
      else if (clr_i[b])
        bit_q <= 1'b0;
    end
    assign en_o[b] = bit_q & IMPL_MASK[b];
  end
endmodule

// File: rtl/isu_line_gate.sv
module isu_line_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic eoi_i,
  output logic irq_o
);
  // Line high == unit disarmed; end-of-service drops it and re-arms.
  logic line_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      line_q <= 1'b0;
    else if (eoi_i)
      line_q <= 1'b0;
    else if (pend_i)
      line_q <= 1'b1;
  end
  assign irq_o = line_q;
endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
  import isu_pkg::*;
#(
  parameter int unsigned         STAT_W    = 10,
  parameter logic [STAT_W-1:0]   IMPL_MASK = 10'h364
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] evt_i,
  input  logic              reg_wr_i,
  input  logic [ISU_AW-1:0] reg_waddr_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  input  logic [ISU_AW-1:0] reg_raddr_i,
  output logic [STAT_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam logic [STAT_W-1:0] ZERO_W = '0;

  logic [STAT_W-1:0] raw_q, en_q, masked;
  logic [STAT_W-1:0] stat_clr, en_set, en_clr;
  logic              eoi_wr;

  always_comb begin
    stat_clr = ZERO_W;
    en_set   = ZERO_W;
    en_clr   = ZERO_W;
    eoi_wr   = 1'b0;
    if (reg_wr_i) begin
      unique case (reg_waddr_i)
        ADR_RAW, ADR_MSK: stat_clr = reg_wdata_i;
        ADR_ENS:          en_set   = reg_wdata_i;
        ADR_ENC:          en_clr   = reg_wdata_i;
        ADR_EOI:          eoi_wr   = 1'b1;
        default:          ;
      endcase
    end
  end

  isu_raw_bank #(.STAT_W(STAT_W), .IMPL_MASK(IMPL_MASK)) u_raw (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_i),
    .clr_i (stat_clr),
    .raw_o (raw_q)
  );

  isu_enable_bank #(.STAT_W(STAT_W), .IMPL_MASK(IMPL_MASK)) u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (en_set),
    .clr_i (en_clr),
    .en_o  (en_q)
  );

  assign masked = raw_q & en_q;

  isu_line_gate u_line (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pend_i(|masked),
    .eoi_i (eoi_wr),
    .irq_o (irq_o)
  );

  always_comb begin
    unique case (reg_raddr_i)
      ADR_RAW:          reg_rdata_o = raw_q;
      ADR_MSK:          reg_rdata_o = masked;
      ADR_ENS, ADR_ENC: reg_rdata_o = en_q;
      default:          reg_rdata_o = ZERO_W;
    endcase
  end
endmodule

// File: rtl/isu_checker.sv
module isu_checker #(
  parameter int unsigned         STAT_W    = 10,
  parameter logic [STAT_W-1:0]   IMPL_MASK = 10'h364
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STAT_W-1:0] evt_i,
  input logic              wr_i,
  input logic [2:0]        waddr_i,
  input logic [STAT_W-1:0] raw_i,
  input logic [STAT_W-1:0] en_i,
  input logic              irq_i
);
  logic eoi;
  assign eoi = wr_i && (waddr_i == 3'd4);

  p_evt_sets_r1_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(evt_i & IMPL_MASK) |=> ((raw_i & $past(evt_i & IMPL_MASK)) == $past(evt_i & IMPL_MASK)));

  p_line_rises_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_i && |(raw_i & en_i) && !eoi) |=> irq_i);

  p_line_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !eoi) |=> irq_i);

  p_eoi_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && eoi) |=> !irq_i);

  p_impl_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_i | en_i) & ~IMPL_MASK) == '0);

  p_no_spurious_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_i && !(|(raw_i & en_i))) |=> !irq_i);
endmodule

bind disp_irq_status isu_checker #(.STAT_W(STAT_W), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .evt_i  (evt_i),
  .wr_i   (reg_wr_i),
  .waddr_i(reg_waddr_i),
  .raw_i  (raw_q),
  .en_i   (en_q),
  .irq_i  (irq_o)
);

// File: tb/tb_disp_irq_status.sv
module tb_disp_irq_status;
  localparam int W = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] evt_i = '0;
  logic         reg_wr_i = 1'b0;
  logic [2:0]   reg_waddr_i = '0;
  logic [W-1:0] reg_wdata_i = '0;
  logic [2:0]   reg_raddr_i = '0;
  logic [W-1:0] reg_rdata_o;
  logic         irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;   // 125 MHz

  disp_irq_status dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i),
    .reg_wr_i(reg_wr_i), .reg_waddr_i(reg_waddr_i), .reg_wdata_i(reg_wdata_i),
    .reg_raddr_i(reg_raddr_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [W-1:0] exp);
    reg_raddr_i = a;
    #1;
    check(req, reg_rdata_o, exp);
  endtask

  // One-cycle write; returns at the following negedge, after the update edge.
  task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input logic [W-1:0] ev);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_waddr_i = a; reg_wdata_i = d; evt_i = ev;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = '0; evt_i = '0;
  endtask

  task automatic pulse(input logic [W-1:0] ev);
    @(negedge clk_i);
    evt_i = ev;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic t_reset;
    rd_check("R10 raw", 3'd0, '0);
    rd_check("R10 enable", 3'd2, '0);
    check("R10 irq", W'(irq_o), '0);
  endtask

  task automatic t_capture;
    pulse(10'h104);
    rd_check("R1 raw after events", 3'd0, 10'h104);
    rd_check("R5 masked with no enables", 3'd1, '0);
    pulse(10'h093);
    rd_check("R9 unimplemented events ignored", 3'd0, 10'h104);
    @(negedge clk_i);
    check("R6 no line with mask empty", W'(irq_o), '0);
  endtask

  task automatic t_enable_and_fire;
    wr(3'd2, 10'h3FF, '0);
    rd_check("R4 R9 enable readback", 3'd2, 10'h364);
    rd_check("R5 masked", 3'd1, 10'h104);
    @(negedge clk_i);
    check("R6 line rises", W'(irq_o), 1);
  endtask

  task automatic t_clear_hold;
    wr(3'd0, 10'h004, '0);
    rd_check("R2 clear bit 2 via raw", 3'd0, 10'h100);
    wr(3'd6, 10'h3FF, '0);
    rd_check("R2 unmapped write ignored", 3'd0, 10'h100);
    wr(3'd1, 10'h100, '0);
    rd_check("R2 clear bit 8 via masked", 3'd0, '0);
    check("R7 line held after clear", W'(irq_o), 1);
    wr(3'd4, 10'h000, '0);
    check("R8 line drops after eoi", W'(irq_o), 0);
    @(negedge clk_i);
    check("R8 stays low when nothing pending", W'(irq_o), 0);
    rd_check("R8 eoi reads zero", 3'd4, '0);
  endtask

  task automatic t_enable_clear;
    wr(3'd3, 10'h020, '0);
    rd_check("R4 clear readback at set addr", 3'd2, 10'h344);
    rd_check("R4 clear readback at clear addr", 3'd3, 10'h344);
  endtask

  task automatic t_collide;
    pulse(10'h020);
    rd_check("R1 disabled bit captured", 3'd0, 10'h020);
    check("R6 disabled bit no line", W'(irq_o), 0);
    wr(3'd0, 10'h060, 10'h020);
    rd_check("R3 event wins over clear", 3'd0, 10'h020);
    wr(3'd0, 10'h020, '0);
    rd_check("R2 final clear", 3'd0, '0);
  endtask

  task automatic t_rearm;
    pulse(10'h200);
    @(negedge clk_i);
    check("R6 frame1 line", W'(irq_o), 1);
    wr(3'd4, 10'h000, '0);
    check("R8 drop on eoi", W'(irq_o), 0);
    @(negedge clk_i);
    check("R8 re-raise while pending", W'(irq_o), 1);
    wr(3'd0, 10'h200, '0);
    wr(3'd4, 10'h000, '0);
    @(negedge clk_i);
    check("R8 quiet after service", W'(irq_o), 0);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_capture();
    t_enable_and_fire();
    t_clear_hold();
    t_enable_clear();
    t_collide();
    t_rearm();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule